// File: doc/BRIEF.md
# Dual-Path Telegram Interrupt Flag Register

This block holds the eight sticky interrupt flags of a two-path telegram receiver. Each path (A and B) has four flags: an early wake check, a start of telegram, an end of telegram and a new-bit event. The flags are set from condition vectors that a demodulator supplies, after masking them with per-path configuration. A start of telegram needs every enabled start condition to be true. The wake check uses the same start mask but leaves out the frame-identifier condition, so it can fire before the frame ID matches. An end of telegram needs any one enabled end condition to be true.

Each end-of-telegram flag has a vector of detail bits, one per end condition, that records which enabled conditions fired. Software clears a flag by writing 1 to its bit. Writing 1 to an end bit also clears that path's detail bits. The interrupt controller clears a flag by pulsing that flag's acknowledge line. Every flag sets on the rising edge of its qualified condition. When a set and a clear land in the same cycle, the set wins.

All pins are plain control and status signals. There is no streaming interface, so no valid/ready handshake and no back-pressure.

Top module: `tgm_irq_flags`

## Requirements
- R1: The flag vector is laid out MSB to LSB as wake B (7), wake A (6), start B (5), start A (4), end B (3), end A (2), new-bit B (1), new-bit A (0). After reset all flags and all detail bits are 0.
- R2: A path's start and wake flags can set only while `rx_on` is 1, `gate_off` is 0 and that path's bit of `path_off` (bit 0 = A, bit 1 = B) is 0.
- R3: A path's start flag sets when every condition enabled in its start mask is true, that is when (cond & mask) == mask.
- R4: A path's wake flag uses the start mask with bit 5 (frame-ID condition) forced to 0. With mask 0xA3 and conditions 0x83, only the wake flag sets. With mask 0x20, only the start flag can set.
- R5: A start mask with no enabled bits never sets the start flag. An effective wake mask with no enabled bits never sets the wake flag.
- R6: A path's end flag sets when any enabled end condition is true. Detail bit i sets when end condition i is enabled and true. Conditions that are not enabled affect neither the flag nor the details.
- R7: A new-bit flag sets on a pulse of that path's `bit_stb` bit.
- R8: A write with `wr_en` clears each flag whose `wr_data` bit is 1. Bits written as 0 leave their flags unchanged.
- R9: A pulse on bit i of `irq_ack` clears flag i.
- R10: Writing 1 to bit 2 (A) or bit 3 (B) clears that path's detail bits and leaves the other path's detail bits alone. An acknowledge does not clear detail bits.
- R11: When a flag's set event and its clear (write or acknowledge) fall in the same cycle, the flag ends up set.
- R12: A flag sets only on a rising edge of its qualified condition. A condition that stays true does not set the flag again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_on | input | 1 | Receiver enabled |
| gate_off | input | 1 | Global filter / power-down qualifier; 1 blocks start and wake |
| path_off | input | 2 | Per-path disable; bit 0 = A, bit 1 = B |
| start_cond_a | input | START_W | Start-of-telegram conditions, path A |
| start_cond_b | input | START_W | Start-of-telegram conditions, path B |
| start_mask_a | input | START_W | Start condition enables, path A |
| start_mask_b | input | START_W | Start condition enables, path B |
| end_cond_a | input | END_W | End-of-telegram conditions, path A |
| end_cond_b | input | END_W | End-of-telegram conditions, path B |
| end_mask_a | input | END_W | End condition enables, path A |
| end_mask_b | input | END_W | End condition enables, path B |
| bit_stb | input | 2 | New-bit strobes; bit 0 = A, bit 1 = B |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_data | input | 8 | Write data; 1 bits clear flags |
| irq_ack | input | 8 | Per-flag service acknowledge pulses |
| flags | output | 8 | Interrupt flag register |
| end_detail_a | output | END_W | End-condition detail bits, path A |
| end_detail_b | output | END_W | End-condition detail bits, path B |

## Verification
The bound checker watches every cycle. It confirms that no start or wake flag rises unless its path was qualified, that a rising start or wake flag was preceded by a full match of its (effective) mask, and that a rising end flag was preceded by an enabled true condition. It also confirms that a rising new-bit flag follows a strobe, that no flag or detail bit falls without a matching write or acknowledge, and that reset leaves everything at 0. Only the directed scenarios can show the other side of each rule: set-beats-clear ordering, the frame-ID exclusion producing a wake without a start, that written zeros and unmasked conditions change nothing, and that a held condition does not set again after a clear.

// File: rtl/tgm_irq_pkg.sv
package tgm_irq_pkg;
  // Two receive paths share one 8-bit flag vector, four kinds of flag.
  localparam int NPATH  = 2;
  localparam int FLAG_W = 8;

  // Lowest bit of each kind; path A at the low bit, path B just above.
  localparam int NBIT_LO = 0;
  localparam int EOT_LO  = 2;
  localparam int SOT_LO  = 4;
  localparam int WAKE_LO = 6;

  typedef enum logic [1:0] {
    K_NBIT = 2'd0,
    K_EOT  = 2'd1,
    K_SOT  = 2'd2,
    K_WAKE = 2'd3
  } flag_kind_e;

  function automatic int flag_pos(flag_kind_e kind, int path);
    return int'(kind) * NPATH + path;
  endfunction
endpackage

// File: rtl/tgm_sticky_bank.sv
// Bank of sticky bits: each sets on a rising edge of its condition and
// clears on request; set has priority over clear in the same cycle.
module tgm_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] cond_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic set_ev;
    assign set_ev = cond[i] & ~cond_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cond_q[i] <= 1'b0;
        q[i]      <= 1'b0;
      end else begin
        cond_q[i] <= cond[i];
        if (set_ev)      q[i] <= 1'b1;
        else if (clr[i]) q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tgm_start_eval.sv
// AND-type evaluation of the start conditions for one path, plus the
// reduced wake check that drops the frame-ID condition from the mask.
module tgm_start_eval #(
  parameter int START_W = 8,
  parameter int FID_BIT = 5
) (
  input  logic               path_ok,
  input  logic [START_W-1:0] cond,
  input  logic [START_W-1:0] mask,
  output logic               sot_hit,
  output logic               wake_hit
);
  localparam logic [START_W-1:0] FID_ONEHOT = START_W'(1) << FID_BIT;

  logic [START_W-1:0] wake_mask;
  logic               sot_all;
  logic               wake_all;

  assign wake_mask = mask & ~FID_ONEHOT;

  // An empty mask is never a match: avoids a vacuous all-true result.
  assign sot_all  = (mask != '0)      && ((cond & mask) == mask);
  assign wake_all = (wake_mask != '0) && ((cond & wake_mask) == wake_mask);

  assign sot_hit  = path_ok & sot_all;
  assign wake_hit = path_ok & wake_all;
endmodule

// File: rtl/tgm_end_eval.sv
// OR-type evaluation of the end conditions for one path.
module tgm_end_eval #(
  parameter int END_W = 8
) (
  input  logic [END_W-1:0] cond,
  input  logic [END_W-1:0] mask,
  output logic [END_W-1:0] masked,
  output logic             any_hit
);
  assign masked  = cond & mask;
  assign any_hit = |masked;
endmodule

// File: rtl/tgm_irq_flags.sv
module tgm_irq_flags
  import tgm_irq_pkg::*;
#(
  parameter int START_W = 8,
  parameter int END_W   = 8,
  parameter int FID_BIT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_on,
  input  logic               gate_off,
  input  logic [1:0]         path_off,
  input  logic [START_W-1:0] start_cond_a,
  input  logic [START_W-1:0] start_cond_b,
  input  logic [START_W-1:0] start_mask_a,
  input  logic [START_W-1:0] start_mask_b,
  input  logic [END_W-1:0]   end_cond_a,
  input  logic [END_W-1:0]   end_cond_b,
  input  logic [END_W-1:0]   end_mask_a,
  input  logic [END_W-1:0]   end_mask_b,
  input  logic [1:0]         bit_stb,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         irq_ack,
  output logic [7:0]         flags,
  output logic [END_W-1:0]   end_detail_a,
  output logic [END_W-1:0]   end_detail_b
);
  // Per-path views of the split ports.
  logic [START_W-1:0] s_cond [NPATH];
  logic [START_W-1:0] s_mask [NPATH];
  logic [END_W-1:0]   e_cond [NPATH];
  logic [END_W-1:0]   e_mask [NPATH];
  logic [END_W-1:0]   e_det  [NPATH];

  assign s_cond[0] = start_cond_a;
  assign s_cond[1] = start_cond_b;
  assign s_mask[0] = start_mask_a;
  assign s_mask[1] = start_mask_b;
  assign e_cond[0] = end_cond_a;
  assign e_cond[1] = end_cond_b;
  assign e_mask[0] = end_mask_a;
  assign e_mask[1] = end_mask_b;

  logic [NPATH-1:0] wake_v;
  logic [NPATH-1:0] sot_v;
  logic [NPATH-1:0] eot_v;
  logic [FLAG_W-1:0] set_v;
  logic [FLAG_W-1:0] clr_v;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic               path_ok;
    logic [END_W-1:0]   masked;
    logic [END_W-1:0]   det_clr;

    assign path_ok = rx_on & ~gate_off & ~path_off[p];

    tgm_start_eval #(
      .START_W (START_W),
      .FID_BIT (FID_BIT)
    ) u_start (
      .path_ok  (path_ok),
      .cond     (s_cond[p]),
      .mask     (s_mask[p]),
      .sot_hit  (sot_v[p]),
      .wake_hit (wake_v[p])
    );

    tgm_end_eval #(
      .END_W (END_W)
    ) u_end (
      .cond    (e_cond[p]),
      .mask    (e_mask[p]),
      .masked  (masked),
      .any_hit (eot_v[p])
    );

    // Detail bits: cleared only by a software write to this path's end bit.
    assign det_clr = {END_W{wr_en & wr_data[EOT_LO + p]}};

    tgm_sticky_bank #(
      .W (END_W)
    ) u_detail (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (masked),
      .clr   (det_clr),
      .q     (e_det[p])
    );
  end

  // Flag layout follows the package offsets: wake, start, end, new-bit.
  assign set_v = {wake_v, sot_v, eot_v, bit_stb};
  assign clr_v = ({FLAG_W{wr_en}} & wr_data) | irq_ack;

  tgm_sticky_bank #(
    .W (FLAG_W)
  ) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .cond  (set_v),
    .clr   (clr_v),
    .q     (flags)
  );

  assign end_detail_a = e_det[0];
  assign end_detail_b = e_det[1];
endmodule

// File: rtl/tgm_irq_flags_chk.sv
module tgm_irq_flags_chk #(
  parameter int START_W = 8,
  parameter int END_W   = 8,
  parameter int FID_BIT = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_on,
  input logic               gate_off,
  input logic [1:0]         path_off,
  input logic [START_W-1:0] start_cond_a,
  input logic [START_W-1:0] start_cond_b,
  input logic [START_W-1:0] start_mask_a,
  input logic [START_W-1:0] start_mask_b,
  input logic [END_W-1:0]   end_cond_a,
  input logic [END_W-1:0]   end_cond_b,
  input logic [END_W-1:0]   end_mask_a,
  input logic [END_W-1:0]   end_mask_b,
  input logic [1:0]         bit_stb,
  input logic               wr_en,
  input logic [7:0]         wr_data,
  input logic [7:0]         irq_ack,
  input logic [7:0]         flags,
  input logic [END_W-1:0]   end_detail_a,
  input logic [END_W-1:0]   end_detail_b
);
  localparam logic [START_W-1:0] NO_FID = ~(START_W'(1) << FID_BIT);

  logic [START_W-1:0] wm_a, wm_b;
  logic [7:0]         clr_req;
  logic               ok_a, ok_b;

  assign wm_a    = start_mask_a & NO_FID;
  assign wm_b    = start_mask_b & NO_FID;
  assign clr_req = ({8{wr_en}} & wr_data) | irq_ack;
  assign ok_a    = rx_on && !gate_off && !path_off[0];
  assign ok_b    = rx_on && !gate_off && !path_off[1];

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (flags == '0 && end_detail_a == '0 && end_detail_b == '0)); // R1
  AST_GATE_A: assert property (@(posedge clk) disable iff (!rst_n) ($rose(flags[4]) || $rose(flags[6])) |-> $past(ok_a)); // R2
  AST_GATE_B: assert property (@(posedge clk) disable iff (!rst_n) ($rose(flags[5]) || $rose(flags[7])) |-> $past(ok_b)); // R2
  AST_START_ALL_A: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[4]) |-> $past(start_mask_a != '0 && (start_cond_a & start_mask_a) == start_mask_a)); // R3
  AST_START_ALL_B: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[5]) |-> $past(start_mask_b != '0 && (start_cond_b & start_mask_b) == start_mask_b)); // R5
  AST_WAKE_A: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[6]) |-> $past(wm_a != '0 && (start_cond_a & wm_a) == wm_a)); // R4
  AST_WAKE_B: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[7]) |-> $past(wm_b != '0 && (start_cond_b & wm_b) == wm_b)); // R4
  AST_END_ANY_A: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[2]) |-> $past((end_cond_a & end_mask_a) != '0)); // R6
  AST_END_ANY_B: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[3]) |-> $past((end_cond_b & end_mask_b) != '0)); // R6
  AST_NBIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) ($rose(flags[0]) || $rose(flags[1])) |-> ($past(bit_stb) != 2'b00)); // R7
  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (($past(flags) & ~flags & ~$past(clr_req)) == '0)); // R8
  AST_DETAIL_A_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (($past(end_detail_a) & ~end_detail_a) != '0) |-> $past(wr_en && wr_data[2])); // R10
  AST_DETAIL_B_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (($past(end_detail_b) & ~end_detail_b) != '0) |-> $past(wr_en && wr_data[3])); // R10
endmodule

bind tgm_irq_flags tgm_irq_flags_chk #(
  .START_W (START_W),
  .END_W   (END_W),
  .FID_BIT (FID_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_on        (rx_on),
  .gate_off     (gate_off),
  .path_off     (path_off),
  .start_cond_a (start_cond_a),
  .start_cond_b (start_cond_b),
  .start_mask_a (start_mask_a),
  .start_mask_b (start_mask_b),
  .end_cond_a   (end_cond_a),
  .end_cond_b   (end_cond_b),
  .end_mask_a   (end_mask_a),
  .end_mask_b   (end_mask_b),
  .bit_stb      (bit_stb),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .irq_ack      (irq_ack),
  .flags        (flags),
  .end_detail_a (end_detail_a),
  .end_detail_b (end_detail_b)
);

// File: tb/sim_tgm_irq_flags.sv
`timescale 1ns/1ps
module sim_tgm_irq_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_on = 1'b0, gate_off = 1'b0;
  logic [1:0] path_off = 2'b00, bit_stb = 2'b00;
  logic [7:0] start_cond_a = '0, start_cond_b = '0, start_mask_a = '0, start_mask_b = '0;
  logic [7:0] end_cond_a = '0, end_cond_b = '0, end_mask_a = '0, end_mask_b = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0, irq_ack = '0;
  logic [7:0] flags, end_detail_a, end_detail_b;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tgm_irq_flags u0 (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .gate_off(gate_off), .path_off(path_off),
    .start_cond_a(start_cond_a), .start_cond_b(start_cond_b),
    .start_mask_a(start_mask_a), .start_mask_b(start_mask_b),
    .end_cond_a(end_cond_a), .end_cond_b(end_cond_b),
    .end_mask_a(end_mask_a), .end_mask_b(end_mask_b),
    .bit_stb(bit_stb), .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack),
    .flags(flags), .end_detail_a(end_detail_a), .end_detail_b(end_detail_b)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle();
    start_cond_a = '0; start_cond_b = '0; start_mask_a = '0; start_mask_b = '0;
    end_cond_a = '0; end_cond_b = '0; end_mask_a = '0; end_mask_b = '0;
    bit_stb = '0; irq_ack = '0; rx_on = 1'b1; gate_off = 1'b0; path_off = 2'b00;
    step();
    wr(8'hFF);
    step();
  endtask

  task automatic t_reset();
    chk("R1 reset flags", flags, 8'h00);
    chk("R1 reset detail A", end_detail_a, 8'h00);
    chk("R1 reset detail B", end_detail_b, 8'h00);
  endtask

  task automatic t_newbit();
    idle();
    bit_stb = 2'b01; step(); bit_stb = 2'b00;
    chk("R7 new-bit A at bit 0", flags, 8'h01);
    bit_stb = 2'b10; step(); bit_stb = 2'b00;
    chk("R7 new-bit B at bit 1", flags, 8'h03);
    wr(8'h01);
    chk("R8 write-one clears bit 0", flags, 8'h02);
    wr(8'h00);
    chk("R8 write zero no effect", flags, 8'h02);
    irq_ack = 8'h02; step(); irq_ack = '0;
    chk("R9 ack clears bit 1", flags, 8'h00);
  endtask

  task automatic t_start();
    idle();
    start_mask_a = 8'hA3; start_cond_a = 8'h22; step();
    chk("R3 partial match no start", flags, 8'h00);
    start_cond_a = 8'hA3; step();
    chk("R3 full match start+wake A", flags, 8'h50);
    idle();
    start_mask_b = 8'hA3; start_cond_b = 8'h83; step();
    chk("R4 wake B without frame-ID", flags, 8'h80);
    start_cond_b = 8'hA3; step();
    chk("R3 start B after frame-ID", flags, 8'hA0);
    idle();
    start_mask_a = 8'h20; start_cond_a = 8'hFF; step();
    chk("R4 frame-ID-only mask no wake", flags, 8'h10);
    idle();
    start_mask_a = 8'h00; start_cond_a = 8'hFF; step(); step();
    chk("R5 empty mask no start/wake", flags, 8'h00);
  endtask

  task automatic t_gate();
    idle();
    start_mask_a = 8'h01; start_cond_a = 8'h01;
    start_mask_b = 8'h01; start_cond_b = 8'h01;
    path_off = 2'b01; step();
    chk("R2 path A disabled, B sets", flags, 8'hA0);
    gate_off = 1'b1; path_off = 2'b00;
    wr(8'hFF); step();
    chk("R2 global gate blocks", flags, 8'h00);
    rx_on = 1'b0; gate_off = 1'b0; step();
    chk("R2 receiver off blocks", flags, 8'h00);
    rx_on = 1'b1; step();
    chk("R2 qualify release sets both", flags, 8'hF0);
  endtask

  task automatic t_end();
    idle();
    end_mask_a = 8'h06; end_cond_a = 8'h04; step();
    chk("R6 end A any-of", flags, 8'h04);
    chk("R6 detail A bit 2", end_detail_a, 8'h04);
    end_cond_a = 8'h05; step();
    chk("R6 unmasked cond ignored", end_detail_a, 8'h04);
    end_cond_a = 8'h07; step();
    chk("R6 detail A adds bit 1", end_detail_a, 8'h06);
    irq_ack = 8'h04; step(); irq_ack = '0;
    chk("R9 ack clears end A", flags, 8'h00);
    chk("R10 ack keeps detail", end_detail_a, 8'h06);
    end_mask_b = 8'h80; end_cond_b = 8'h80; step();
    chk("R6 end B at bit 3", flags, 8'h08);
    wr(8'h04);
    chk("R10 write end A clears detail A", end_detail_a, 8'h00);
    chk("R10 detail B untouched", end_detail_b, 8'h80);
    step(); step();
    chk("R12 held end cond no re-set", flags, 8'h08);
    wr(8'h08);
    chk("R10 write end B clears detail B", end_detail_b, 8'h00);
    step();
    chk("R12 held cond stays cleared", flags, 8'h00);
  endtask

  task automatic t_setwins();
    idle();
    bit_stb = 2'b01; step(); bit_stb = 2'b00; step();
    bit_stb = 2'b01; wr_en = 1'b1; wr_data = 8'h01; step();
    bit_stb = 2'b00; wr_en = 1'b0; wr_data = '0;
    chk("R11 set beats write clear", flags, 8'h01);
    step();
    bit_stb = 2'b01; irq_ack = 8'h01; step();
    bit_stb = 2'b00; irq_ack = '0;
    chk("R11 set beats ack clear", flags, 8'h01);
    wr(8'hFE);
    chk("R8 other bits written keep bit 0", flags, 8'h01);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_newbit();
    t_start();
    t_gate();
    t_end();
    t_setwins();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule